// File: doc/BRIEF.md
# Variable-Length CPU Bus Cycle Sequencer

This block paces a 16-bit console processor that runs from one fast master clock through a clock enable. Each processor bus cycle spans a whole number of enabled master ticks, and that number depends on what the cycle does. A cycle that touches nothing lasts 6 ticks. A memory access lasts 8 ticks. An access to the I/O register space lasts 12 ticks. At the first tick of every cycle the sequencer raises an opening strobe, where the processor evaluates and memory reads are launched. Near the middle of the cycle it raises a mid-cycle strobe, where writes are launched.

When a DMA transfer owns the bus, the processor is stalled. Every cycle then lasts a fixed 8 ticks, with the read on the opening strobe and the write on the mid-cycle strobe. A pause input lets a frame synchroniser stall the machine, but it only takes effect between cycles, so an access that has started always finishes. The current position inside the cycle is available as a phase count.

Top module: `cpu_cycle_sequencer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `phase` to 0. While `rst` is high, neither strobe is asserted in any cycle where `tick_en` is low.
- R2: Class code 2'b00 (no access) gives a cycle of 6 ticks, with `strobe_rise` at phase 2.
- R3: Class code 2'b01 (memory) gives a cycle of 8 ticks, with `strobe_rise` at phase 3.
- R4: Class codes 2'b10 and 2'b11 (I/O) give a cycle of 12 ticks, with `strobe_rise` at phase 5. `phase` never reaches 12.
- R5: `strobe_fall` is asserted only in a tick at phase 0 that is not paused, exactly once per cycle. It is never asserted together with `strobe_rise`. `strobe_rise` is asserted exactly once per cycle.
- R6: `acc_class` and `dma_active` are sampled only at the phase-0 tick. Changing them later in the cycle does not change the cycle's length or its rise phase.
- R7: When `dma_active` is high at the phase-0 tick, the cycle lasts 8 ticks with the rise at phase 3, whatever the class code.
- R8: When `pause` is high at a phase-0 tick, `phase` stays at 0 and both strobes stay low. When `pause` is high at any other phase, it has no effect.
- R9: In a clock cycle with `tick_en` low, `phase` keeps its value and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Master-tick enable; one tick per clock where high |
| acc_class | input | 2 | Access class of the next cycle: 00 none, 01 memory, 1x I/O |
| dma_active | input | 1 | DMA owns the bus; forces an 8-tick cycle |
| pause | input | 1 | Stall request, honoured at a cycle boundary only |
| strobe_fall | output | 1 | Opening strobe at phase 0 (compute, reads) |
| strobe_rise | output | 1 | Mid-cycle strobe (writes) |
| phase | output | 4 | Tick position inside the current cycle |

## Verification
The hardest behaviour to reach is the sampling window. The class and DMA inputs must be seen only at the boundary tick, yet a wrong design that reads them later looks correct whenever they hold steady. Each table cycle therefore changes the class to a different length class, and flips the DMA flag, straight after the opening tick, and then measures both the length and the rise phase. Pause is applied both at a boundary and in the middle of a cycle, and reset is applied in the middle of a cycle, so the boundary-only rule and the restart are seen from the outputs.

// File: rtl/cyc_seq_pkg.sv
package cyc_seq_pkg;

    typedef enum logic [1:0] {
        ACC_NONE   = 2'b00,
        ACC_MEM    = 2'b01,
        ACC_IO     = 2'b10,
        ACC_IO_ALT = 2'b11
    } acc_class_e;

    parameter int unsigned DEF_TICKS_NONE = 6;
    parameter int unsigned DEF_TICKS_MEM  = 8;
    parameter int unsigned DEF_TICKS_IO   = 12;
    parameter int unsigned DEF_TICKS_DMA  = 8;

    function automatic int unsigned max4(int unsigned a, int unsigned b,
                                         int unsigned c, int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    // Write strobe sits at half the cycle length minus one.
    function automatic int unsigned rise_of(int unsigned len);
        return (len / 2) - 1;
    endfunction

endpackage

// File: rtl/cyc_len_select.sv
module cyc_len_select
    import cyc_seq_pkg::*;
#(
    parameter int unsigned TICKS_NONE = DEF_TICKS_NONE,
    parameter int unsigned TICKS_MEM  = DEF_TICKS_MEM,
    parameter int unsigned TICKS_IO   = DEF_TICKS_IO,
    parameter int unsigned TICKS_DMA  = DEF_TICKS_DMA,
    parameter int unsigned CNT_W      = 4
) (
    input  acc_class_e       cls,
    input  logic             dma,
    output logic [CNT_W-1:0] len
);
    always_comb begin
        if (dma) begin
            len = CNT_W'(TICKS_DMA);
        end else begin
            unique case (cls)
                ACC_NONE:          len = CNT_W'(TICKS_NONE);
                ACC_MEM:           len = CNT_W'(TICKS_MEM);
                ACC_IO, ACC_IO_ALT: len = CNT_W'(TICKS_IO);
                default:           len = CNT_W'(TICKS_IO);
            endcase
        end
    end
endmodule

// File: rtl/cyc_phase_ctr.sv
module cyc_phase_ctr
    import cyc_seq_pkg::*;
#(
    parameter int unsigned TICKS_NONE = DEF_TICKS_NONE,
    parameter int unsigned TICKS_MAX  = DEF_TICKS_IO,
    parameter int unsigned CNT_W      = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             pause,
    input  logic [CNT_W-1:0] sel_len,
    output logic [CNT_W-1:0] phase,
    output logic [CNT_W-1:0] cur_len
);
    logic [CNT_W-1:0] phase_q;
    logic [CNT_W-1:0] len_q;
    logic             at_start;
    logic             at_last;

    assign at_start = (phase_q == '0);
    assign at_last  = (phase_q == len_q - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            len_q   <= CNT_W'(TICKS_NONE);
        end else if (tick_en) begin
            if (at_start) begin
                if (!pause) begin
                    len_q   <= sel_len;
                    phase_q <= CNT_W'(1);
                end
            end else if (at_last) begin
                phase_q <= '0;
            end else begin
                phase_q <= phase_q + CNT_W'(1);
            end
        end
    end

    assign phase   = phase_q;
    assign cur_len = len_q;

    p_hold_no_tick_r9: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(phase_q));
    p_pause_boundary_r8: assert property (@(posedge clk) disable iff (rst)
        (tick_en && at_start && pause) |=> (phase_q == '0));
    p_pause_midcycle_r8: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !at_start && pause) |=> (phase_q != $past(phase_q)));
    p_phase_bound_r4: assert property (@(posedge clk) disable iff (rst)
        tick_en |=> (phase_q < CNT_W'(TICKS_MAX)));
endmodule

// File: rtl/cyc_strobe_gen.sv
module cyc_strobe_gen
    import cyc_seq_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             pause,
    input  logic [CNT_W-1:0] phase,
    input  logic [CNT_W-1:0] cur_len,
    output logic             fall,
    output logic             rise
);
    logic [CNT_W-1:0] rise_pt;

    assign rise_pt = (cur_len >> 1) - CNT_W'(1);
    assign fall    = tick_en && (phase == '0) && !pause;
    assign rise    = tick_en && (phase != '0) && (phase == rise_pt);

    p_fall_advances_r5: assert property (@(posedge clk) disable iff (rst)
        fall |=> (phase == CNT_W'(1)));
    p_strobes_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
        !(fall && rise));
    p_rise_advances_r3: assert property (@(posedge clk) disable iff (rst)
        rise |=> (phase != '0) && (phase != $past(phase)));
endmodule

// File: rtl/cpu_cycle_sequencer.sv
module cpu_cycle_sequencer
    import cyc_seq_pkg::*;
#(
    parameter int unsigned TICKS_NONE = DEF_TICKS_NONE,
    parameter int unsigned TICKS_MEM  = DEF_TICKS_MEM,
    parameter int unsigned TICKS_IO   = DEF_TICKS_IO,
    parameter int unsigned TICKS_DMA  = DEF_TICKS_DMA
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic [1:0] acc_class,
    input  logic       dma_active,
    input  logic       pause,
    output logic       strobe_fall,
    output logic       strobe_rise,
    output logic [3:0] phase
);
    localparam int unsigned TICKS_MAX = max4(TICKS_NONE, TICKS_MEM, TICKS_IO, TICKS_DMA);
    localparam int unsigned CNT_W     = $clog2(TICKS_MAX + 1);

    logic [CNT_W-1:0] sel_len;
    logic [CNT_W-1:0] phase_w;
    logic [CNT_W-1:0] cur_len;
    acc_class_e       cls;

    assign cls = acc_class_e'(acc_class);

    cyc_len_select #(
        .TICKS_NONE(TICKS_NONE), .TICKS_MEM(TICKS_MEM),
        .TICKS_IO(TICKS_IO), .TICKS_DMA(TICKS_DMA), .CNT_W(CNT_W)
    ) u_len (
        .cls(cls), .dma(dma_active), .len(sel_len)
    );

    cyc_phase_ctr #(
        .TICKS_NONE(TICKS_NONE), .TICKS_MAX(TICKS_MAX), .CNT_W(CNT_W)
    ) u_ctr (
        .clk(clk), .rst(rst), .tick_en(tick_en), .pause(pause),
        .sel_len(sel_len), .phase(phase_w), .cur_len(cur_len)
    );

    cyc_strobe_gen #(.CNT_W(CNT_W)) u_strb (
        .clk(clk), .rst(rst), .tick_en(tick_en), .pause(pause),
        .phase(phase_w), .cur_len(cur_len),
        .fall(strobe_fall), .rise(strobe_rise)
    );

    assign phase = 4'(phase_w);

    p_reset_phase_r1: assert property (@(posedge clk)
        rst |=> (phase == 4'd0));
endmodule

// File: tb/test_cpu_cycle_sequencer.sv
module test_cpu_cycle_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;

    // class at phase 0, dma at phase 0, class after opening tick, expected length, expected rise
    localparam int V_CLS  [NV] = '{0, 1, 2, 3, 0, 2, 1, 0};
    localparam int V_DMA  [NV] = '{0, 0, 0, 0, 1, 1, 0, 0};
    localparam int V_MID  [NV] = '{2, 0, 0, 1, 2, 0, 2, 1};
    localparam int V_LEN  [NV] = '{6, 8, 12, 12, 8, 8, 8, 6};
    localparam int V_RISE [NV] = '{2, 3, 5, 5, 3, 3, 3, 2};

    logic       clk = 0;
    logic       rst = 1;
    logic       tick_en = 0;
    logic [1:0] acc_class = 0;
    logic       dma_active = 0;
    logic       pause = 0;
    logic       strobe_fall, strobe_rise;
    logic [3:0] phase;

    int checks = 0;
    int errors = 0;
    logic s_fall, s_rise;
    logic [3:0] s_phase;

    cpu_cycle_sequencer i_cpu_cycle_sequencer (
        .clk(clk), .rst(rst), .tick_en(tick_en), .acc_class(acc_class),
        .dma_active(dma_active), .pause(pause),
        .strobe_fall(strobe_fall), .strobe_rise(strobe_rise), .phase(phase)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One enabled tick: sample outputs mid-low-phase, then let the edge pass.
    task automatic tick();
        tick_en = 1;
        #1;
        s_fall = strobe_fall; s_rise = strobe_rise; s_phase = phase;
        @(negedge clk);
    endtask

    task automatic run_cycle(input int cls, input int dma, input int mid,
                             input int pz_mid, output int len, output int rph,
                             output int nrise, output int nfall, output int first_fall);
        acc_class = 2'(cls); dma_active = dma[0]; pause = 0;
        tick();
        first_fall = int'(s_fall);
        len = 1; rph = -1; nrise = int'(s_rise); nfall = 0;
        acc_class = 2'(mid); dma_active = ~dma[0];   // R6: late change must be ignored
        pause = pz_mid[0];
        while (phase != 4'd0 && len < 20) begin
            tick();
            len++;
            if (s_rise) begin nrise++; rph = int'(s_phase); end
            if (s_fall) nfall++;
        end
        tick_en = 0; pause = 0; dma_active = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int len, rph, nrise, nfall, ff;
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        check(phase == 0, "R1 phase in reset", int'(phase), 0);
        check(!strobe_fall && !strobe_rise, "R1 strobes in reset", int'(strobe_fall), 0);
        rst = 0;
        @(negedge clk);

        // Table of cycles: R2, R3, R4, R6, R7
        for (int i = 0; i < NV; i++) begin
            run_cycle(V_CLS[i], V_DMA[i], V_MID[i], 0, len, rph, nrise, nfall, ff);
            check(ff == 1, "R5 opening strobe", ff, 1);
            check(nfall == 0, "R5 single opening strobe", nfall, 0);
            check(nrise == 1, "R5 single rise strobe", nrise, 1);
            check(len == V_LEN[i], V_DMA[i] != 0 ? "R7 dma length" :
                  (V_LEN[i] == 6 ? "R2 length" : (V_LEN[i] == 8 ? "R3 length" : "R4 length")),
                  len, V_LEN[i]);
            check(rph == V_RISE[i], "R6 rise phase after late class change", rph, V_RISE[i]);
        end

        // R9: no ticks, nothing moves
        acc_class = 2'd1;
        tick_en = 1; #1; @(negedge clk);          // start an 8-tick cycle, now at phase 1
        tick_en = 0;
        tick(); tick_en = 0;                       // now at phase 2
        for (int k = 0; k < 4; k++) begin
            #1;
            check(phase == 2 && !strobe_fall && !strobe_rise, "R9 hold without tick", int'(phase), 2);
            @(negedge clk);
        end
        // finish that cycle
        while (phase != 0) tick();
        tick_en = 0;

        // R8: pause at boundary freezes
        pause = 1;
        for (int k = 0; k < 3; k++) begin
            tick();
            check(!s_fall && !s_rise, "R8 strobes held under pause", int'(s_fall), 0);
            check(phase == 0, "R8 phase frozen at boundary", int'(phase), 0);
        end
        tick_en = 0; pause = 0;

        // R8: pause mid-cycle has no effect (12-tick cycle)
        run_cycle(2, 0, 0, 1, len, rph, nrise, nfall, ff);
        check(len == 12, "R8 mid-cycle pause ignored length", len, 12);
        check(rph == 5, "R8 mid-cycle pause ignored rise", rph, 5);

        // R1: reset in mid-cycle restarts at phase 0
        acc_class = 2'd2;
        tick(); tick(); tick();
        tick_en = 0;
        rst = 1; @(negedge clk); rst = 0;
        #1;
        check(phase == 0, "R1 mid-cycle reset", int'(phase), 0);
        @(negedge clk);
        run_cycle(0, 0, 0, 0, len, rph, nrise, nfall, ff);
        check(len == 6 && ff == 1, "R2 first cycle after reset", len, 6);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule